// File: doc/BRIEF.md
# Token-Ring Round-Robin Arbiter

This block shares one resource among N requesters. Each requester owns one cell in a ring of identical cells. A single token bit is held by exactly one cell and moves one place downstream on every clock edge, whether or not anyone was served. In the current cycle, the cell holding the token gets the first chance to serve its own requester. If that requester is idle, the chance passes downstream to the next cell, and so on around the ring. The first requesting cell that the chance reaches receives the grant.

Seen as equations, the cells form a combinational loop. That loop is only meaningful because exactly one token bit is set, which breaks it at the holder. The implementation therefore does not build the loop. It computes each cell's "chance arrives here" signal directly: a cell has the chance when a stretch of idle cells runs from the token holder up to, but not including, that cell. The per-cell grant and pass equations are then applied to that signal.

The grant is combinational from the request inputs and the token register, so it answers in the same cycle. Synchronous reset places the token in cell 0.

Top module: `token_ring_arbiter`

## Requirements
- R1: While reset is high on a clock edge, the token is loaded into cell 0. In the first cycle after reset, with every request high, the grant is bit 0 only.
- R2: The token advances from cell i to cell (i+1) mod N on every clock edge outside reset. With all requests held high, the granted index after k edges since reset is k mod N.
- R3: At most one grant bit is high in any cycle.
- R4: The grant goes to the first cell with its request high, searching in ring order from the token holder and wrapping from cell N-1 to cell 0.
- R5: When no request is high, the grant vector is zero. The token still advances during those cycles.
- R6: A grant bit is high only when the request bit of the same index is high.
- R7: When the token holder's request is high, that cell is the one granted.
- R8: For every cell, the chance to grant equals the upstream cell's pass output OR the cell's own token bit. The pass output is "chance and no request".
- R9: The grant responds to a request change in the same cycle, with no register between the request and grant ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_REQ | Request, one bit per requester |
| grant | output | N_REQ | Grant, zero or one-hot |

## Verification
The bench builds the arbiter with N_REQ = 5. This size is not a power of two, so the wrap from cell 4 back to cell 0 is off any natural binary boundary. It is also small enough that every token position recurs many times within a short run. A vector table steps the token through every cell with requests placed before, at and after the holder, including searches that travel almost the whole ring. A pseudo-random sweep then compares the grant against an independent search model. The sweep also exercises the pass-link equivalence between the loop-free search and the cyclic cell equations.

// File: rtl/tra_pkg.sv
package tra_pkg;

  localparam int unsigned MIN_CELLS = 2;
  localparam int unsigned MAX_CELLS = 16;

  // Index of the upstream neighbour in a ring of n cells.
  function automatic int unsigned ring_up(input int unsigned i, input int unsigned n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  // Index of the downstream neighbour in a ring of n cells.
  function automatic int unsigned ring_down(input int unsigned i, input int unsigned n);
    return (i == n - 1) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/tra_token_ring.sv
module tra_token_ring #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [N_CELLS-1:0] token
);
  import tra_pkg::*;

  localparam logic [N_CELLS-1:0] TOKEN_INIT = {{(N_CELLS-1){1'b0}}, 1'b1};

  logic [N_CELLS-1:0] token_q;
  logic [N_CELLS-1:0] token_d;

  // Each cell's next token bit is its upstream neighbour's current bit.
  for (genvar c = 0; c < N_CELLS; c++) begin : g_shift
    localparam int unsigned UP = ring_up(c, N_CELLS);
    assign token_d[c] = token_q[UP];
  end

  always_ff @(posedge clk) begin
    if (rst) token_q <= TOKEN_INIT;
    else     token_q <= token_d;
  end

  assign token = token_q;

  // R2
  token_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(token_q));

  // R2
  token_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> token_q == {$past(token_q[N_CELLS-2:0]), $past(token_q[N_CELLS-1])});

endmodule

// File: rtl/tra_go_search.sv
module tra_go_search #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic [N_CELLS-1:0] token,
  input  logic [N_CELLS-1:0] req,
  output logic [N_CELLS-1:0] go
);
  // A cell has the chance when the token sits at some source cell and every
  // cell from the source up to the one before this cell has no request.
  // The search walks backwards from the cell, so the result never feeds back.
  always_comb begin
    for (int c = 0; c < N_CELLS; c++) begin
      logic blocked;
      int   src;
      blocked = 1'b0;
      go[c]   = 1'b0;
      for (int d = 0; d < N_CELLS; d++) begin
        src = (c + N_CELLS - d) % N_CELLS;
        if (d > 0) blocked = blocked | req[src];
        if (token[src] && !blocked) go[c] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tra_cell.sv
module tra_cell (
  input  logic req,
  input  logic go,
  output logic ok,
  output logic pass
);
  assign ok   = req & go;
  assign pass = ~req & go;
endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter #(
  parameter int unsigned N_REQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  import tra_pkg::*;

  logic [N_REQ-1:0] token;
  logic [N_REQ-1:0] go;
  logic [N_REQ-1:0] pass;

  initial begin
    size_ok_chk: assert (N_REQ >= MIN_CELLS && N_REQ <= MAX_CELLS);
  end

  tra_token_ring #(.N_CELLS(N_REQ)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .token (token)
  );

  tra_go_search #(.N_CELLS(N_REQ)) u_search (
    .token (token),
    .req   (req),
    .go    (go)
  );

  for (genvar c = 0; c < N_REQ; c++) begin : g_cell
    localparam int unsigned UP = ring_up(c, N_REQ);

    tra_cell u_cell (
      .req  (req[c]),
      .go   (go[c]),
      .ok   (grant[c]),
      .pass (pass[c])
    );

    // R8
    go_link_chk: assert property (@(posedge clk) disable iff (rst)
      go[c] == (pass[UP] | token[c]));
  end

  // R3
  grant_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6
  grant_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

  // R7
  holder_served_chk: assert property (@(posedge clk) disable iff (rst)
    ((token & req) != '0) |-> (grant == (token & req)));

  // R5
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (grant == '0));

endmodule

// File: tb/token_ring_arbiter_bench.sv
module token_ring_arbiter_bench;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;

  always #5 clk = ~clk;

  token_ring_arbiter #(.N_REQ(N)) u_token_ring_arbiter (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant)
  );

  // {req, expected grant}; token at step k is k mod 5
  localparam int NV = 14;
  localparam logic [2*N-1:0] VEC [NV] = '{
    {5'b11111, 5'b00001}, {5'b11111, 5'b00010}, {5'b00000, 5'b00000},
    {5'b00001, 5'b00001}, {5'b00100, 5'b00100}, {5'b10010, 5'b00010},
    {5'b00001, 5'b00001}, {5'b00100, 5'b00100}, {5'b00110, 5'b00010},
    {5'b10001, 5'b10000}, {5'b11110, 5'b00010}, {5'b00000, 5'b00000},
    {5'b00011, 5'b00001}, {5'b01000, 5'b01000}
  };

  function automatic logic [N-1:0] model(input logic [N-1:0] r, input int p);
    logic [N-1:0] g;
    logic found;
    g = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && r[(p + k) % N]) begin
        g[(p + k) % N] = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b (token pos %0d)", tag, act, exp, pos);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    pos = 0;
  endtask

  // Drive during the cycle, sample before the next edge, then advance.
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] exp, input string tag);
    req = r;
    #2;
    check(tag, grant, exp);
    @(negedge clk);
    pos = (pos + 1) % N;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;

    // Reset state: grant zero with no requests (R5), then R1
    do_reset();
    req = '0;
    #2;
    check("R5 idle after reset", grant, '0);
    do_reset();
    step('1, 5'b00001, "R1 token at cell 0 after reset");

    // Vector table (R4, R5, R7)
    do_reset();
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][2*N-1:N], VEC[k][N-1:0], "R4 ring-order table");
    end

    // Rotation with all requests (R2)
    do_reset();
    for (int k = 0; k < 3 * N; k++) begin
      step('1, 5'b00001 << (k % N), "R2 rotation");
    end

    // Idle cycles still rotate the token (R5)
    do_reset();
    step('0, '0, "R5 idle no grant");
    step('0, '0, "R5 idle no grant");
    step('1, 5'b00100, "R5 token moved during idle");

    // Same-cycle response (R9)
    req = 5'b00000;
    #1;
    check("R9 no grant before request", grant, '0);
    req = 5'b01000;
    #1;
    check("R9 same-cycle grant", grant, 5'b01000);
    @(negedge clk);
    pos = (pos + 1) % N;

    // Reset mid-run returns token to cell 0 (R1)
    do_reset();
    step(5'b10000, 5'b10000, "R1 wrap search from cell 0");

    // Pseudo-random sweep against model (R3, R4, R6, R8)
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req = lfsr[N-1:0];
      #2;
      check("R4 sweep model", grant, model(lfsr[N-1:0], pos));
      check("R3 at most one grant", {{(N-1){1'b0}}, $countones(grant) > 1}, '0);
      check("R6 grant implies request", grant & ~req, '0);
      @(negedge clk);
      pos = (pos + 1) % N;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule